// File: doc/BRIEF.md
# Leading-Edge Blanking Timer

This block opens a one-shot blanking window after chosen switching events in a PWM generator. During that window a current-sense or fault input is forced to zero, so the ringing that follows a switch transition cannot raise a false fault. Eight start sources can each be enabled on their own:

- the rising and falling edges of the high-side PWM output;
- the rising and falling edges of the low-side PWM output;
- four compare-event pulses, named A to D.

A single 32-bit configuration register, reached through a simple write/read port, holds the eight enables and a 16-bit period field. The window lasts one clock more than the period field, and it never lasts fewer than five clocks. A start source that fires while a window is open restarts the window at its full length. The period is sampled when each window starts, so a register write does not stretch or shorten a window that is already running. The block outputs a blank-active flag and a gated copy of the sense input.

Top module: `leb_timer`

## Requirements
- R1: After reset the configuration register reads 0x0000_0000, `blank_active` is low and no start source is enabled.
- R2: A write stores bits 31:24 (enables) and bits 19:4 (period field). Bits 23:20 and 3:0 always read as zero, whatever value was written to them.
- R3: Register bits 28, 29, 30 and 31 enable compare-event pulses A, B, C and D as start sources. These pulses arrive on `cmp_evt[0]` to `cmp_evt[3]`.
- R4: Bit 27 enables the rising edge of `pwm_hi` as a start source, and bit 26 enables its falling edge.
- R5: Bit 25 enables the rising edge of `pwm_lo` as a start source, and bit 24 enables its falling edge.
- R6: A source whose enable bit is clear has no effect: `blank_active` stays low.
- R7: An enabled trigger seen at clock edge T makes `blank_active` high from edge T+1. It then stays high for exactly (period field + 1) cycles.
- R8: Period field values 0 to 4 all give a 5-cycle window. A field value of 5 gives 6 cycles.
- R9: An enabled trigger that arrives during an open window reloads the window, which then runs its full length from that trigger.
- R10: While `blank_active` is high, `sense_masked` is 0. While it is low, `sense_masked` equals `sense_in`.
- R11: The window length is taken from the register at the trigger. A write made while the window is open changes only the windows that start later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current register contents |
| pwm_hi | input | 1 | High-side PWM output being watched |
| pwm_lo | input | 1 | Low-side PWM output being watched |
| cmp_evt | input | 4 | Compare-event pulses, one per bit: bit 0 is A, bit 3 is D |
| sense_in | input | 1 | Raw sense or fault input |
| blank_active | output | 1 | High while the blanking window is open |
| sense_masked | output | 1 | `sense_in` gated by the blanking window |

## Verification
A wrong count or a wrong load value shows up at the end of the window. In that case `blank_active` falls one or more cycles early or late, so the bench measures the exact length of each window, cycle by cycle, at the ports. A wrong edge history or a wrong enable mapping shows up one cycle after the stimulus: either a window opens when the source is disabled, or no window opens when it is enabled. The bench drives each source with only one enable set at a time. A window that does not reload on a retrigger, or a period that is sampled too late, shows up only at the end of the window, and the bench compares that end against the expected cycle.

// File: rtl/leb_pkg.sv
package leb_pkg;
  // register layout
  localparam int REG_W   = 32;
  localparam int EN_LSB  = 24;
  localparam int N_SRC   = 8;
  localparam int PER_LSB = 4;
  localparam int PER_W   = 16;
  localparam int N_PWM   = 2;
  localparam int N_EVT   = 4;

  // start source index inside the enable byte
  typedef enum logic [2:0] {
    SRC_LO_FALL = 3'd0,
    SRC_LO_RISE = 3'd1,
    SRC_HI_FALL = 3'd2,
    SRC_HI_RISE = 3'd3,
    SRC_EVT_A   = 3'd4,
    SRC_EVT_B   = 3'd5,
    SRC_EVT_C   = 3'd6,
    SRC_EVT_D   = 3'd7
  } src_idx_e;

  typedef struct packed {
    logic [N_SRC-1:0] src_en;
    logic [PER_W-1:0] period;
  } leb_cfg_t;
endpackage

// File: rtl/leb_cfg_reg.sv
module leb_cfg_reg
  import leb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output leb_cfg_t         cfg,
  output logic [REG_W-1:0] rdata
);
  localparam int EN_MSB  = EN_LSB + N_SRC - 1;
  localparam int PER_MSB = PER_LSB + PER_W - 1;
  localparam int GAP_W   = EN_LSB - PER_MSB - 1;

  leb_cfg_t cfg_q;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata[EN_LSB-1:PER_MSB+1], wdata[PER_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.src_en <= wdata[EN_MSB:EN_LSB];
      cfg_q.period <= wdata[PER_MSB:PER_LSB];
    end
  end

  assign cfg   = cfg_q;
  assign rdata = {cfg_q.src_en, {GAP_W{1'b0}}, cfg_q.period, {PER_LSB{1'b0}}};
endmodule

// File: rtl/leb_trig_detect.sv
module leb_trig_detect
  import leb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PWM-1:0] pwm,     // [0]=low side, [1]=high side
  input  logic [N_EVT-1:0] evt,
  input  logic [N_SRC-1:0] src_en,
  output logic             trig
);
  logic [N_PWM-1:0] pwm_q;
  logic [N_SRC-1:0] raw;

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= '0;
    else     pwm_q <= pwm;
  end

  // per-channel fall/rise detection
  for (genvar ch = 0; ch < N_PWM; ch++) begin : g_edge
    assign raw[2*ch]   = ~pwm[ch] &  pwm_q[ch];
    assign raw[2*ch+1] =  pwm[ch] & ~pwm_q[ch];
  end

  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    assign raw[2*N_PWM+e] = evt[e];
  end

  assign trig = |(raw & src_en);
endmodule

// File: rtl/leb_window.sv
module leb_window #(
  parameter int PER_W   = 16,
  parameter int MIN_WIN = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [PER_W-1:0] period,
  output logic             active
);
  localparam logic [PER_W-1:0] MIN_LOAD = PER_W'(MIN_WIN - 1);

  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] load_val;
  logic             active_q;

  // remaining cycles after this one; clamp short periods
  assign load_val = (period < MIN_LOAD) ? MIN_LOAD : period;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (trig) begin
      cnt_q    <= load_val;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active = active_q;
endmodule

// File: rtl/leb_timer.sv
module leb_timer
  import leb_pkg::*;
#(
  parameter int MIN_WIN = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        pwm_hi,
  input  logic        pwm_lo,
  input  logic [3:0]  cmp_evt,
  input  logic        sense_in,
  output logic        blank_active,
  output logic        sense_masked
);
  leb_cfg_t cfg;
  logic     trig_hit;
  logic     win_active;

  leb_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  leb_trig_detect u_det (
    .clk    (clk),
    .rst    (rst),
    .pwm    ({pwm_hi, pwm_lo}),
    .evt    (cmp_evt),
    .src_en (cfg.src_en),
    .trig   (trig_hit)
  );

  leb_window #(.PER_W(PER_W), .MIN_WIN(MIN_WIN)) u_win (
    .clk    (clk),
    .rst    (rst),
    .trig   (trig_hit),
    .period (cfg.period),
    .active (win_active)
  );

  assign blank_active = win_active;
  assign sense_masked = sense_in & ~win_active;
endmodule

// File: rtl/leb_timer_chk.sv
module leb_timer_chk #(
  parameter int MIN_WIN = 5
) (
  input logic        clk,
  input logic        rst,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        trig,
  input logic        sense_in,
  input logic        blank_active,
  input logic        sense_masked
);
  logic [17:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)               run_len <= '0;
    else if (!blank_active) run_len <= '0;
    else if (run_len != '1) run_len <= run_len + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!blank_active && cfg_rdata == 32'h0));

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (cfg_rdata[31:24] == $past(cfg_wdata[31:24]) &&
                cfg_rdata[19:4]  == $past(cfg_wdata[19:4])));

  // R7
  trig_open_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> blank_active);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[31:24] == 8'h00 && !blank_active) |=> !blank_active);

  // R8
  min_window_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(blank_active) |-> (run_len >= 18'(MIN_WIN)));

  // R10
  sense_gate_chk: assert property (@(posedge clk) disable iff (rst)
    blank_active |-> !sense_masked);

  // R10
  sense_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !blank_active |-> (sense_masked == sense_in));
endmodule

bind leb_timer leb_timer_chk #(.MIN_WIN(MIN_WIN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .trig         (trig_hit),
  .sense_in     (sense_in),
  .blank_active (blank_active),
  .sense_masked (sense_masked)
);

// File: tb/tb_leb_timer.sv
`timescale 1ns/1ps
module tb_leb_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pwm_hi = 1'b0;
  logic        pwm_lo = 1'b0;
  logic [3:0]  cmp_evt = '0;
  logic        sense_in = 1'b0;
  logic        blank_active;
  logic        sense_masked;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  leb_timer dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .cmp_evt(cmp_evt), .sense_in(sense_in),
    .blank_active(blank_active), .sense_masked(sense_masked)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk(input int en_bit, input int field);
    return (32'h1 << en_bit) | (32'(field) << 4);
  endfunction

  // kind 0: pwm_hi <= val, 1: pwm_lo <= val, 2..5: pulse event A..D
  task automatic fire(input int kind, input bit val, output int len);
    @(negedge clk);
    case (kind)
      0: pwm_hi = val;
      1: pwm_lo = val;
      default: cmp_evt[kind-2] = 1'b1;
    endcase
    @(negedge clk);
    cmp_evt = '0;
    len = 0;
    while (blank_active && len < 100000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cfg_rdata == 32'h0, "R1 reg", cfg_rdata, 0);
    check(blank_active == 1'b0, "R1 blank", blank_active, 0);
  endtask

  task automatic t_readback;
    write_cfg(32'hFFFF_FFFF);
    check(cfg_rdata == 32'hFF0F_FFF0, "R2 all ones", cfg_rdata, 32'hFF0F_FFF0);
    write_cfg(32'h5AA5_C33F);
    check(cfg_rdata == 32'h5A05_C330, "R2 pattern", cfg_rdata, 32'h5A05_C330);
  endtask

  task automatic t_events;
    int len;
    for (int k = 0; k < 4; k++) begin
      write_cfg(mk(28 + k, 10));
      fire(2 + k, 1'b1, len);
      check(len == 11, "R3 R7 event enabled", len, 11);
      fire(2 + ((k + 1) % 4), 1'b1, len);
      check(len == 0, "R6 other event ignored", len, 0);
    end
  endtask

  task automatic t_hi_edges;
    int len;
    write_cfg(mk(27, 10));
    fire(0, 1'b1, len); check(len == 11, "R4 hi rise", len, 11);
    fire(0, 1'b0, len); check(len == 0, "R6 hi fall ignored", len, 0);
    write_cfg(mk(26, 10));
    fire(0, 1'b1, len); check(len == 0, "R6 hi rise ignored", len, 0);
    fire(0, 1'b0, len); check(len == 11, "R4 hi fall", len, 11);
    fire(1, 1'b1, len); check(len == 0, "R6 lo edge ignored", len, 0);
    fire(1, 1'b0, len);
  endtask

  task automatic t_lo_edges;
    int len;
    write_cfg(mk(25, 6));
    fire(1, 1'b1, len); check(len == 7, "R5 lo rise", len, 7);
    fire(1, 1'b0, len); check(len == 0, "R6 lo fall ignored", len, 0);
    write_cfg(mk(24, 6));
    fire(1, 1'b1, len); check(len == 0, "R6 lo rise ignored", len, 0);
    fire(1, 1'b0, len); check(len == 7, "R5 lo fall", len, 7);
  endtask

  task automatic t_min;
    int len;
    for (int f = 0; f <= 4; f++) begin
      write_cfg(mk(28, f));
      fire(2, 1'b1, len);
      check(len == 5, "R8 clamp", len, 5);
    end
    write_cfg(mk(28, 5));
    fire(2, 1'b1, len); check(len == 6, "R8 field 5", len, 6);
    write_cfg(mk(28, 4095));
    fire(2, 1'b1, len); check(len == 4096, "R7 long", len, 4096);
  endtask

  task automatic t_retrig;
    int len = 0;
    write_cfg(mk(28, 9));
    @(negedge clk);
    cmp_evt[0] = 1'b1;
    @(negedge clk);
    cmp_evt = '0;
    while (blank_active && len < 1000) begin
      len++;
      if (len == 4) cmp_evt[0] = 1'b1;
      @(negedge clk);
      cmp_evt = '0;
    end
    check(len == 14, "R9 retrigger", len, 14);
  endtask

  task automatic t_sense;
    int len = 0;
    int bad = 0;
    write_cfg(mk(28, 7));
    sense_in = 1'b1;
    @(negedge clk);
    check(sense_masked == 1'b1, "R10 pass before", sense_masked, 1);
    cmp_evt[0] = 1'b1;
    @(negedge clk);
    cmp_evt = '0;
    while (blank_active && len < 1000) begin
      len++;
      if (sense_masked != 1'b0) bad++;
      @(negedge clk);
    end
    check(bad == 0 && len == 8, "R10 masked in window", bad, 0);
    check(sense_masked == 1'b1, "R10 pass after", sense_masked, 1);
    sense_in = 1'b0;
    @(negedge clk);
    check(sense_masked == 1'b0, "R10 follows low", sense_masked, 0);
  endtask

  task automatic t_capture;
    int len = 0;
    write_cfg(mk(28, 19));
    @(negedge clk);
    cmp_evt[0] = 1'b1;
    @(negedge clk);
    cmp_evt = '0;
    while (blank_active && len < 1000) begin
      len++;
      if (len == 3) begin cfg_we = 1'b1; cfg_wdata = mk(28, 2); end
      @(negedge clk);
      cfg_we = 1'b0;
    end
    check(len == 20, "R11 running window kept", len, 20);
    check(cfg_rdata == mk(28, 2), "R11 new value stored", cfg_rdata, mk(28, 2));
    fire(2, 1'b1, len);
    check(len == 5, "R11 next window uses new", len, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_events();
    t_hi_edges();
    t_lo_edges();
    t_min();
    t_retrig();
    t_sense();
    t_capture();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule